// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block decodes the addresses of two bus masters that share one memory system: an instruction master and a data master. Each transfer address is steered to exactly one target. The targets are dynamic memory, static memory, an external boot port, a second bridge port, or a default error slave. The block also drives a translated address for the chosen target. Four strap inputs shape the decode. A remap flag makes a chosen boot memory appear in the lowest 64 MB after reset.

At reset the remap flag is set. While it is set, the boot window (addresses below `2**WIN_W`) shows one of three things, depending on the straps: dynamic memory unchanged, the static boot region, or the off-chip boot region. When the window is redirected, the address keeps its low `WIN_W` bits and its upper bits are replaced by the base of the new region.

Software clears the flag with a one-cycle strobe. After that the window decodes as plain dynamic memory until the next reset. Outside the window, only the controller-select strap and the bridge-map strap affect the decode.

Select and translated-address outputs are registered in the address phase. They advance only while `hready` is high.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is applied and until the first enabled update after it, `i_sel` and `d_sel` are all zero. The remap flag comes out of reset set.
- R2: Select bits are laid out as: bit0 dynamic memory, bit1 static memory, bit2 external boot port, bit3 bridge port, bit4 error slave. Outside the boot window, the address ranges map as follows, and the translated address equals the input:
  - 0x0000_0000–0x3FFF_FFFF selects dynamic memory.
  - 0x4000_0000–0x7FFF_FFFF selects static memory.
  - 0x8000_0000–0x8FFF_FFFF selects the external boot port.
  - 0x9000_0000–0x9FFF_FFFF selects the bridge port.
  - Every other address selects the error slave.
- R3: With `dyn_serves_static` high, static-range addresses select dynamic memory (bit0) instead of static memory.
- R4: With the flag set, `boot_offchip` low and `boot_static` high, a window address selects the static path. That is bit1, or bit0 when `dyn_serves_static` is high. The translated address is {0x40000000[31:26], addr[25:0]}.
- R5: With the flag set and both `boot_offchip` and `boot_static` low, a window address selects dynamic memory and the address is unchanged.
- R6: With the flag set and `boot_offchip` high, an instruction-master window address selects the external boot port (bit2). A data-master window address does the same when `bridge_by_addr` is high. The translated address is {0x80000000[31:26], addr[25:0]}.
- R7: With the flag set, `boot_offchip` high and `bridge_by_addr` low, a data-master window address selects the bridge port (bit3). This is the only case where the same address gives different selects on the two masters.
- R8: A high `remap_clear` clears the flag at the next clock edge. From then on, window addresses select dynamic memory with the address unchanged. Only reset sets the flag again.
- R9: While `hready` is low, the select and translated-address outputs hold their values.
- R10: A transfer sampled with its valid low drives that master's select to all zero.
- R11: Each select output has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hready | input | 1 | Address-phase advance enable |
| i_valid | input | 1 | Instruction master transfer request |
| i_addr | input | 32 | Instruction master address |
| d_valid | input | 1 | Data master transfer request |
| d_addr | input | 32 | Data master address |
| boot_static | input | 1 | Strap: static boot region may be aliased into the window |
| dyn_serves_static | input | 1 | Strap: dynamic memory controller also serves the static range |
| bridge_by_addr | input | 1 | Strap: bridge port chosen by address (high) or by master (low) |
| boot_offchip | input | 1 | Strap: boot memory is off-chip |
| remap_clear | input | 1 | Write strobe that clears the remap flag |
| i_sel | output | 5 | Registered one-hot target select, instruction master |
| d_sel | output | 5 | Registered one-hot target select, data master |
| i_maddr | output | 32 | Registered translated address, instruction master |
| d_maddr | output | 32 | Registered translated address, data master |

## Verification
The bench uses the default parameters: a 32-bit address, a 26-bit boot window, and the standard region limits. With these values, the window edge at 0x03FF_FFFF/0x0400_0000 and the end of the bridge range at 0x9FFF_FFFF/0xA000_0000 fall on exact addresses the bench can drive. The redirected bases give translated values that can be predicted from the straps alone. Every strap combination that affects the window is driven on both masters at once, so the single divergent case is checked against the cases where the masters must agree. The flag is cleared and then restored by a second reset.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int NSLV = 5;
  typedef enum logic [2:0] {
    SL_DYN  = 3'd0,
    SL_STAT = 3'd1,
    SL_EXTB = 3'd2,
    SL_BRG  = 3'd3,
    SL_ERR  = 3'd4
  } slave_e;
endpackage

// File: rtl/brd_remap_flag.sv
module brd_remap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic flag
);
  logic flag_q, flag_nxt;

  always_comb begin
    flag_nxt = flag_q;
    if (clear) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_nxt;
  end

  assign flag = flag_q;
endmodule

// File: rtl/brd_addr_map.sv
module brd_addr_map
  import brd_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          WIN_W   = 26,
  parameter bit          IS_DATA = 1'b0,
  parameter logic [31:0] DYN_LO  = 32'h0000_0000,
  parameter logic [31:0] DYN_HI  = 32'h3FFF_FFFF,
  parameter logic [31:0] STAT_LO = 32'h4000_0000,
  parameter logic [31:0] STAT_HI = 32'h7FFF_FFFF,
  parameter logic [31:0] EXT_LO  = 32'h8000_0000,
  parameter logic [31:0] EXT_HI  = 32'h8FFF_FFFF,
  parameter logic [31:0] BRG_LO  = 32'h9000_0000,
  parameter logic [31:0] BRG_HI  = 32'h9FFF_FFFF
) (
  input  logic [AW-1:0] addr,
  input  logic          remap_on,
  input  logic          boot_static,
  input  logic          dyn_serves_static,
  input  logic          bridge_by_addr,
  input  logic          boot_offchip,
  output slave_e        tgt,
  output logic [AW-1:0] maddr
);
  localparam int HI_W = AW - WIN_W;
  localparam logic [AW-1:0] DLO = DYN_LO[AW-1:0];
  localparam logic [AW-1:0] DHI = DYN_HI[AW-1:0];
  localparam logic [AW-1:0] SLO = STAT_LO[AW-1:0];
  localparam logic [AW-1:0] SHI = STAT_HI[AW-1:0];
  localparam logic [AW-1:0] ELO = EXT_LO[AW-1:0];
  localparam logic [AW-1:0] EHI = EXT_HI[AW-1:0];
  localparam logic [AW-1:0] BLO = BRG_LO[AW-1:0];
  localparam logic [AW-1:0] BHI = BRG_HI[AW-1:0];

  logic   in_win;
  slave_e fixed_tgt;
  slave_e stat_path;

  assign in_win    = (addr[AW-1:WIN_W] == '0);
  assign stat_path = dyn_serves_static ? SL_DYN : SL_STAT;

  always_comb begin
    if      (addr >= DLO && addr <= DHI) fixed_tgt = SL_DYN;
    else if (addr >= SLO && addr <= SHI) fixed_tgt = stat_path;
    else if (addr >= ELO && addr <= EHI) fixed_tgt = SL_EXTB;
    else if (addr >= BLO && addr <= BHI) fixed_tgt = SL_BRG;
    else                                 fixed_tgt = SL_ERR;
  end

  always_comb begin
    tgt   = fixed_tgt;
    maddr = addr;
    if (remap_on && in_win) begin
      if (boot_offchip) begin
        maddr = {ELO[AW-1 -: HI_W], addr[WIN_W-1:0]};
        tgt   = (IS_DATA && !bridge_by_addr) ? SL_BRG : SL_EXTB;
      end else if (boot_static) begin
        maddr = {SLO[AW-1 -: HI_W], addr[WIN_W-1:0]};
        tgt   = stat_path;
      end else begin
        tgt   = SL_DYN;
      end
    end
  end
endmodule

// File: rtl/brd_sel_reg.sv
module brd_sel_reg
  import brd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            valid,
  input  slave_e          tgt,
  input  logic [AW-1:0]   maddr_in,
  output logic [NSLV-1:0] sel,
  output logic [AW-1:0]   maddr
);
  logic [NSLV-1:0] sel_q, sel_nxt;
  logic [AW-1:0]   addr_q, addr_nxt;

  always_comb begin
    sel_nxt  = sel_q;
    addr_nxt = addr_q;
    if (en) begin
      addr_nxt = maddr_in;
      for (int k = 0; k < NSLV; k++)
        sel_nxt[k] = valid && (tgt == slave_e'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel_nxt;
      addr_q <= addr_nxt;
    end
  end

  assign sel   = sel_q;
  assign maddr = addr_q;
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import brd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int WIN_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hready,
  input  logic            i_valid,
  input  logic [AW-1:0]   i_addr,
  input  logic            d_valid,
  input  logic [AW-1:0]   d_addr,
  input  logic            boot_static,
  input  logic            dyn_serves_static,
  input  logic            bridge_by_addr,
  input  logic            boot_offchip,
  input  logic            remap_clear,
  output logic [NSLV-1:0] i_sel,
  output logic [NSLV-1:0] d_sel,
  output logic [AW-1:0]   i_maddr,
  output logic [AW-1:0]   d_maddr
);
  localparam int NMST = 2;

  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  logic       remap_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  brd_remap_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clear (remap_clear),
    .flag  (remap_on)
  );

  logic [AW-1:0]   m_addr  [NMST];
  logic            m_valid [NMST];
  slave_e          m_tgt   [NMST];
  logic [AW-1:0]   m_xaddr [NMST];
  logic [NSLV-1:0] m_sel   [NMST];
  logic [AW-1:0]   m_maddr [NMST];

  assign m_addr[0]  = i_addr;
  assign m_addr[1]  = d_addr;
  assign m_valid[0] = i_valid;
  assign m_valid[1] = d_valid;

  for (genvar m = 0; m < NMST; m++) begin : g_mst
    brd_addr_map #(
      .AW      (AW),
      .WIN_W   (WIN_W),
      .IS_DATA (m == 1)
    ) u_map (
      .addr              (m_addr[m]),
      .remap_on          (remap_on),
      .boot_static       (boot_static),
      .dyn_serves_static (dyn_serves_static),
      .bridge_by_addr    (bridge_by_addr),
      .boot_offchip      (boot_offchip),
      .tgt               (m_tgt[m]),
      .maddr             (m_xaddr[m])
    );

    brd_sel_reg #(.AW(AW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .en       (hready),
      .valid    (m_valid[m]),
      .tgt      (m_tgt[m]),
      .maddr_in (m_xaddr[m]),
      .sel      (m_sel[m]),
      .maddr    (m_maddr[m])
    );
  end

  assign i_sel   = m_sel[0];
  assign d_sel   = m_sel[1];
  assign i_maddr = m_maddr[0];
  assign d_maddr = m_maddr[1];
endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk #(
  parameter int AW = 32,
  parameter int NS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic          i_valid,
  input logic [AW-1:0] i_addr,
  input logic          d_valid,
  input logic [AW-1:0] d_addr,
  input logic          bridge_by_addr,
  input logic          boot_offchip,
  input logic [NS-1:0] i_sel,
  input logic [NS-1:0] d_sel,
  input logic [AW-1:0] i_maddr
);
  localparam logic [AW-1:0] ERR_FLOOR = AW'(32'hA000_0000);

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(i_sel) && $onehot0(d_sel));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(i_sel) && $stable(d_sel) && $stable(i_maddr));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hready && !i_valid |=> i_sel == '0);

  a_r2_error: assert property (@(posedge clk) disable iff (!rst_n)
    hready && i_valid && i_addr >= ERR_FLOOR |=> i_sel == NS'(5'b10000));

  a_r7_agree: assert property (@(posedge clk) disable iff (!rst_n)
    hready && i_valid && d_valid && i_addr == d_addr
      && !(boot_offchip && !bridge_by_addr) |=> i_sel == d_sel);
endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(.AW(AW), .NS(brd_pkg::NSLV)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_sync),
  .hready         (hready),
  .i_valid        (i_valid),
  .i_addr         (i_addr),
  .d_valid        (d_valid),
  .d_addr         (d_addr),
  .bridge_by_addr (bridge_by_addr),
  .boot_offchip   (boot_offchip),
  .i_sel          (i_sel),
  .d_sel          (d_sel),
  .i_maddr        (i_maddr)
);

// File: tb/boot_remap_decoder_test.sv
module boot_remap_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hready, i_valid, d_valid;
  logic [31:0] i_addr, d_addr;
  logic        boot_static, dyn_serves_static, bridge_by_addr, boot_offchip;
  logic        remap_clear;
  logic [4:0]  i_sel, d_sel;
  logic [31:0] i_maddr, d_maddr;

  int checks = 0;
  int errors = 0;

  localparam logic [4:0] S_DYN = 5'b00001, S_STAT = 5'b00010,
                         S_EXT = 5'b00100, S_BRG  = 5'b01000,
                         S_ERR = 5'b10000;

  always #5 clk = ~clk;

  boot_remap_decoder uut (
    .clk(clk), .rst_n(rst_n), .hready(hready),
    .i_valid(i_valid), .i_addr(i_addr), .d_valid(d_valid), .d_addr(d_addr),
    .boot_static(boot_static), .dyn_serves_static(dyn_serves_static),
    .bridge_by_addr(bridge_by_addr), .boot_offchip(boot_offchip),
    .remap_clear(remap_clear),
    .i_sel(i_sel), .d_sel(d_sel), .i_maddr(i_maddr), .d_maddr(d_maddr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic straps(input logic st, input logic dss, input logic bba, input logic off);
    boot_static = st; dyn_serves_static = dss; bridge_by_addr = bba; boot_offchip = off;
  endtask

  task automatic issue(input logic iv, input logic [31:0] ia, input logic dv, input logic [31:0] da);
    @(negedge clk);
    i_valid = iv; i_addr = ia; d_valid = dv; d_addr = da;
    @(posedge clk); #1;
    check("R11 i onehot", 32'($countones(i_sel) <= 1), 32'd1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; i_valid = 0; d_valid = 0; hready = 1; remap_clear = 0;
    i_addr = 0; d_addr = 0;
    repeat (3) @(negedge clk);
    check("R1 i_sel in reset", 32'(i_sel), 32'd0);
    check("R1 d_sel in reset", 32'(d_sel), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 i_sel after reset", 32'(i_sel), 32'd0);
  endtask

  task automatic t_static_boot();
    straps(1, 0, 1, 0);
    issue(1, 32'h0000_1234, 1, 32'h03FF_FFFC);
    check("R4 i_sel static", 32'(i_sel), 32'(S_STAT));
    check("R4 i_maddr", i_maddr, 32'h4000_1234);
    check("R4 d_maddr window top", d_maddr, 32'h43FF_FFFC);
    straps(1, 1, 1, 0);
    issue(1, 32'h0000_1234, 0, 0);
    check("R4 R3 i_sel dyn path", 32'(i_sel), 32'(S_DYN));
    check("R4 i_maddr dyn path", i_maddr, 32'h4000_1234);
  endtask

  task automatic t_fixed_map();
    straps(1, 0, 1, 0);
    issue(1, 32'h0400_0000, 1, 32'h3FFF_FFFF);
    check("R2 above window dyn", 32'(i_sel), 32'(S_DYN));
    check("R2 above window addr", i_maddr, 32'h0400_0000);
    check("R2 dyn top", 32'(d_sel), 32'(S_DYN));
    issue(1, 32'h4000_0010, 1, 32'h7FFF_FFFF);
    check("R2 static", 32'(i_sel), 32'(S_STAT));
    check("R2 static top", 32'(d_sel), 32'(S_STAT));
    straps(1, 1, 1, 0);
    issue(1, 32'h4000_0010, 0, 0);
    check("R3 static via dyn", 32'(i_sel), 32'(S_DYN));
    issue(1, 32'h8000_0000, 1, 32'h8FFF_FFFF);
    check("R2 ext boot", 32'(i_sel), 32'(S_EXT));
    check("R2 ext boot top", 32'(d_sel), 32'(S_EXT));
    issue(1, 32'h9FFF_FFFC, 1, 32'h9000_0000);
    check("R2 bridge", 32'(i_sel), 32'(S_BRG));
    check("R2 bridge addr", i_maddr, 32'h9FFF_FFFC);
    check("R2 bridge d", 32'(d_sel), 32'(S_BRG));
    issue(1, 32'hA000_0000, 1, 32'hFFFF_FFFF);
    check("R2 error", 32'(i_sel), 32'(S_ERR));
    check("R2 error top", 32'(d_sel), 32'(S_ERR));
  endtask

  task automatic t_dyn_boot();
    straps(0, 0, 1, 0);
    issue(1, 32'h0000_0100, 1, 32'h0000_0100);
    check("R5 i_sel", 32'(i_sel), 32'(S_DYN));
    check("R5 i_maddr", i_maddr, 32'h0000_0100);
    check("R5 d_sel", 32'(d_sel), 32'(S_DYN));
  endtask

  task automatic t_offchip();
    straps(1, 0, 1, 1);
    issue(1, 32'h0000_0200, 1, 32'h0000_0200);
    check("R6 i_sel", 32'(i_sel), 32'(S_EXT));
    check("R6 d_sel", 32'(d_sel), 32'(S_EXT));
    check("R6 i_maddr", i_maddr, 32'h8000_0200);
    straps(1, 0, 0, 1);
    issue(1, 32'h0000_0200, 1, 32'h0000_0200);
    check("R7 i_sel ext", 32'(i_sel), 32'(S_EXT));
    check("R7 d_sel bridge", 32'(d_sel), 32'(S_BRG));
    check("R7 d_maddr", d_maddr, 32'h8000_0200);
    issue(1, 32'h4000_0000, 1, 32'h4000_0000);
    check("R7 outside window agree", 32'(d_sel), 32'(S_STAT));
  endtask

  task automatic t_valid_hready();
    straps(1, 0, 1, 0);
    issue(0, 32'h9000_0000, 1, 32'h9000_0000);
    check("R10 i idle", 32'(i_sel), 32'd0);
    check("R10 d active", 32'(d_sel), 32'(S_BRG));
    issue(1, 32'h9000_0000, 1, 32'h8000_0000);
    @(negedge clk);
    hready = 0; i_addr = 32'hB000_0000; d_valid = 0;
    @(posedge clk); #1;
    check("R9 i_sel held", 32'(i_sel), 32'(S_BRG));
    check("R9 i_maddr held", i_maddr, 32'h9000_0000);
    check("R9 d_sel held", 32'(d_sel), 32'(S_EXT));
    @(negedge clk);
    hready = 1;
    @(posedge clk); #1;
    check("R9 resumes", 32'(i_sel), 32'(S_ERR));
  endtask

  task automatic t_clear();
    @(negedge clk);
    i_valid = 0; d_valid = 0; remap_clear = 1;
    @(negedge clk);
    remap_clear = 0;
    straps(1, 0, 0, 1);
    issue(1, 32'h0000_0300, 1, 32'h0000_0300);
    check("R8 i_sel dyn", 32'(i_sel), 32'(S_DYN));
    check("R8 d_sel dyn", 32'(d_sel), 32'(S_DYN));
    check("R8 addr unchanged", i_maddr, 32'h0000_0300);
    repeat (3) @(negedge clk);
    issue(1, 32'h0000_0300, 0, 0);
    check("R8 stays clear", 32'(i_sel), 32'(S_DYN));
    do_reset();
    issue(1, 32'h0000_0300, 0, 0);
    check("R8 reset sets flag", 32'(i_sel), 32'(S_EXT));
    check("R8 reset maddr", i_maddr, 32'h8000_0300);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    straps(1, 0, 1, 0);
    do_reset();
    t_static_boot();
    t_fixed_map();
    t_dyn_boot();
    t_offchip();
    t_valid_hready();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule